// File: doc/BRIEF.md
# Asynchronous Serial Port with Byte-Bus Control Register

This block is a full-duplex asynchronous serial port programmed through a byte-wide register bus. Software sees two registers. A control register selects the frame format, enables the receiver and holds the status flags. A data register starts a transmission when written and returns the last accepted received byte when read. Frames have either eight data bits, or eight data bits plus a ninth bit. The ninth bit can carry data or act as an address marker in a multidrop network. When address filtering is on, the receiver accepts only frames whose ninth bit is set.

Bit timing comes from the `baud_tick` strobe. It must pulse at 16 times the bit rate; that oversampling factor is the `TICKS_PER_BIT` parameter. The receiver finds a start bit on a falling edge of the line and confirms it at the middle of the start bit. It then samples every later bit at its midpoint. A status bit for a bad stop bit shares the top control-bit position with a mode bit. The `fe_select` input picks which of the two that position reads and writes. Both the transmit and the receive completion flags are set by hardware and cleared only by software.

Top module: `serial_port_ctrl`

## Requirements
- R1: After reset the control register reads 00h, the stop-bit error flag is clear and `txd` is high.
- R2: A read at address 98h returns the control byte. Its bits, from bit 7 down to bit 0, are SM0, SM1, SM2, REN, TB8, RB8, TI, RI, and a write at 98h loads them in the same positions. A read at 99h returns the receive buffer. Any other address reads 00h. The mode field {SM0,SM1} means: 01 for 8-bit frames, 10 and 11 for 9-bit frames, and 00 for idle.
- R3: With `fe_select` high, bit 7 at 98h reads and writes the stop-bit error flag, and SM0 keeps its value. Hardware sets the flag whenever a completed frame has a low stop bit. Only a software write clears it.
- R4: In mode 01, a write at 99h while the transmitter is idle sends one frame on `txd`: a low start bit, the eight data bits LSB first, then a high stop bit. Each bit lasts `TICKS_PER_BIT` ticks. TB8 is not sent in this mode.
- R5: In modes 10 and 11, the transmitted frame carries TB8 as a ninth bit between the last data bit and the stop bit.
- R6: TI is set when the last data bit (the ninth bit in 9-bit modes) has finished, which is when the stop bit begins. TI stays set until software clears it.
- R7: In mode 00, a write at 99h sends nothing, and frames on `rxd` are not received.
- R8: Frames are received only while REN is 1. Clearing REN in the middle of a frame abandons that frame, so neither RI nor the buffer changes.
- R9: A low pulse on `rxd` that is high again at the middle of the start bit is dropped. The receiver then accepts the next valid frame.
- R10: In mode 01, an accepted frame loads the buffer, copies its stop bit into RB8 and sets RI. With SM2 set, a frame with a low stop bit is not accepted.
- R11: In 9-bit modes, RB8 gets the received ninth bit. With SM2 set, a frame whose ninth bit is 0 changes neither the buffer, RB8 nor RI.
- R12: While RI is set, a new frame does not change the buffer or RB8. Hardware never clears RI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling strobe, `TICKS_PER_BIT` per bit |
| fe_select | input | 1 | Routes control bit 7 to the stop-bit error flag |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The bench sends frames that the receiver must refuse: a low stop bit under SM2, a zero ninth bit under SM2, a frame arriving in mode 00, and a frame arriving while RI is still set. A filter that failed here would overwrite the buffer, raise RI or corrupt RB8. The bench also checks that the ninth transmitted slot carries TB8 only in 9-bit modes, and that TI rises exactly at the start of the stop bit, so an off-by-one in the bit counter shows up. Further runs cover a start glitch, REN dropped in mid-frame, and the bit-7 overlay. These catch a receiver that hangs after a false start, that finishes a frame it should have abandoned, or that lets an error-flag write disturb SM0.

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl #(
  parameter int TICKS_PER_BIT = 16,
  parameter logic [7:0] CTRL_ADDR = 8'h98,
  parameter logic [7:0] DATA_ADDR = 8'h99
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       fe_select,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd
);
  localparam int CW = $clog2(TICKS_PER_BIT);
  localparam logic [CW-1:0] CNT_MAX = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(TICKS_PER_BIT / 2 - 1);

  logic sm0, sm1, sm2, ren, tb8, rb8, ti, ri, fe;
  logic [7:0] rx_buf;

  wire ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
  wire data_wr = bus_wr && (bus_addr == DATA_ADDR);
  wire nine    = sm0;
  wire mode_on = sm0 | sm1;
  wire [3:0] last_bit = nine ? 4'd10 : 4'd9;

  assign bus_rdata = (bus_addr == CTRL_ADDR) ? {fe_select ? fe : sm0, sm1, sm2, ren, tb8, rb8, ti, ri} :
                     (bus_addr == DATA_ADDR) ? rx_buf : 8'h00;

  // transmitter
  logic          tx_busy;
  logic [10:0]   tx_sh;
  logic [CW-1:0] tx_cnt;
  logic [3:0]    tx_bit;

  wire tx_step = tx_busy && baud_tick && (tx_cnt == CNT_MAX);
  wire ti_set  = tx_step && (tx_bit == last_bit - 4'd1);
  assign txd = tx_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_cnt  <= '0;
      tx_bit  <= '0;
    end else if (!tx_busy) begin
      if (data_wr && mode_on) begin
        tx_busy <= 1'b1;
        tx_sh   <= nine ? {1'b1, tb8, bus_wdata, 1'b0} : {2'b11, bus_wdata, 1'b0};
        tx_cnt  <= '0;
        tx_bit  <= '0;
      end
    end else if (baud_tick) begin
      if (tx_cnt == CNT_MAX) begin
        tx_cnt <= '0;
        tx_sh  <= {1'b1, tx_sh[10:1]};
        if (tx_bit == last_bit) tx_busy <= 1'b0;
        else tx_bit <= tx_bit + 4'd1;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  // receiver
  logic          rxd_m, rxd_s, rxd_q;
  logic          rx_on;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_bit;
  logic [7:0]    rx_sh;
  logic          rx_ninth;

  wire rx_samp   = rx_on && baud_tick && (rx_bit != 4'd0) && (rx_cnt == CNT_MAX);
  wire rx_end    = rx_samp && (rx_bit == last_bit);
  wire stop_ok   = rxd_s;
  wire addr_ok   = !sm2 || (nine ? rx_ninth : stop_ok);
  wire rx_accept = rx_end && !ri && addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
      rxd_q <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
      rxd_q <= rxd_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on    <= 1'b0;
      rx_cnt   <= '0;
      rx_bit   <= '0;
      rx_sh    <= '0;
      rx_ninth <= 1'b0;
    end else if (!ren || !mode_on) begin
      rx_on <= 1'b0;
    end else if (!rx_on) begin
      if (rxd_q && !rxd_s) begin
        rx_on  <= 1'b1;
        rx_cnt <= '0;
        rx_bit <= '0;
      end
    end else if (baud_tick) begin
      if (rx_bit == 4'd0) begin
        if (rx_cnt == CNT_HALF) begin
          if (rxd_s) rx_on <= 1'b0;
          else begin
            rx_cnt <= '0;
            rx_bit <= 4'd1;
          end
        end else begin
          rx_cnt <= rx_cnt + 1'b1;
        end
      end else if (rx_cnt == CNT_MAX) begin
        rx_cnt <= '0;
        if (rx_bit <= 4'd8) rx_sh <= {rxd_s, rx_sh[7:1]};
        else if (rx_bit == 4'd9 && nine) rx_ninth <= rxd_s;
        if (rx_bit == last_bit) rx_on <= 1'b0;
        else rx_bit <= rx_bit + 4'd1;
      end else begin
        rx_cnt <= rx_cnt + 1'b1;
      end
    end
  end

  // control register and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sm0, sm1, sm2, ren, tb8, rb8, ti, ri} <= '0;
      fe     <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (ctrl_wr) begin
        if (fe_select) fe <= bus_wdata[7];
        else sm0 <= bus_wdata[7];
        {sm1, sm2, ren, tb8, rb8, ti, ri} <= bus_wdata[6:0];
      end
      if (ti_set) ti <= 1'b1;
      if (rx_end && !stop_ok) fe <= 1'b1;
      if (rx_accept) begin
        rx_buf <= rx_sh;
        rb8    <= nine ? rx_ninth : stop_ok;
        ri     <= 1'b1;
      end
    end
  end

  assert_ri_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !ctrl_wr) |=> ri);
  assert_buf_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ri |=> $stable(rx_buf));
  assert_ti_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !ctrl_wr) |=> ti);
  assert_ti_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ti) && !$past(ctrl_wr)) |-> tx_busy);
  assert_ren_stops_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> !rx_on);
  assert_fe_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !ctrl_wr) |=> fe);
endmodule

// File: tb/serial_port_ctrl_test.sv
module serial_port_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       fe_select = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rxd = 1'b1;
  logic       txd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fe_select(fe_select),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd)
  );

  // {ctrl, data, ninth, stop, expect_ri, expect_rb8}
  localparam logic [19:0] VEC [10] = '{
    {8'h50, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'h50, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h70, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h70, 8'h22, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'h90, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h90, 8'h81, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'hF0, 8'h77, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'hF0, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'hD0, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h10, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic send(input logic [7:0] d, input bit nine, input bit ninth, input bit stop);
    @(negedge clk);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
    if (nine) begin
      rxd = ninth;
      repeat (16) @(negedge clk);
    end
    rxd = stop;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic tx_frame(input string req, input logic [7:0] d, input bit nine, input bit tb8);
    int nb;
    logic exp;
    logic [7:0] r;
    nb = nine ? 11 : 10;
    wr(8'h99, d);
    repeat (8) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      if (k == 0) exp = 1'b0;
      else if (k <= 8) exp = d[k-1];
      else if (k == 9 && nine) exp = tb8;
      else exp = 1'b1;
      check(req, {7'd0, txd}, {7'd0, exp});
      if (k == nb - 2) begin
        rd(8'h98, r);
        check("R6 TI before stop", {7'd0, r[1]}, 8'h00);
      end
      if (k == nb - 1) begin
        rd(8'h98, r);
        check("R6 TI at stop", {7'd0, r[1]}, 8'h01);
      end
      if (k != nb - 1) repeat (16) @(negedge clk);
    end
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] last_buf;
    int bad;
    last_buf = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h98, r); check("R1 ctrl reset", r, 8'h00);
    check("R1 txd idle", {7'd0, txd}, 8'h01);
    fe_select = 1'b1;
    rd(8'h98, r); check("R1 fe reset", r, 8'h00);
    fe_select = 1'b0;
    rd(8'h42, r); check("R2 unmapped read", r, 8'h00);
    wr(8'h98, 8'hAB);
    rd(8'h98, r); check("R2 ctrl readback", r, 8'hAB);
    wr(8'h98, 8'h00);

    // receive vectors: R7 R10 R11
    foreach (VEC[i]) begin
      logic [7:0] c, d;
      logic ninth, stop, eri, erb8;
      {c, d, ninth, stop, eri, erb8} = VEC[i];
      wr(8'h98, c);
      send(d, c[7], ninth, stop);
      rd(8'h98, r);
      check(c[7] ? "R11 ctrl after frame" : (c[7:6] == 2'b00 ? "R7 ctrl after frame" : "R10 ctrl after frame"),
            r, {c[7:3], erb8, 1'b0, eri});
      if (eri) last_buf = d;
      rd(8'h99, r);
      check(c[7] ? "R11 buffer" : (c[7:6] == 2'b00 ? "R7 buffer" : "R10 buffer"), r, last_buf);
    end

    // overrun guard R12
    wr(8'h98, 8'h50);
    send(8'h12, 1'b0, 1'b0, 1'b1);
    send(8'h34, 1'b0, 1'b0, 1'b0);
    rd(8'h99, r); check("R12 buffer kept", r, 8'h12);
    rd(8'h98, r); check("R12 rb8 and ri kept", r, 8'h55);

    // false start R9
    wr(8'h98, 8'h50);
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd(8'h98, r); check("R9 glitch ignored", r, 8'h50);
    send(8'hE7, 1'b0, 1'b0, 1'b1);
    rd(8'h99, r); check("R9 next frame data", r, 8'hE7);

    // REN gating R8
    wr(8'h98, 8'h40);
    send(8'h21, 1'b0, 1'b0, 1'b1);
    rd(8'h98, r); check("R8 ren off no ri", r, 8'h40);
    wr(8'h98, 8'h50);
    fork
      send(8'h66, 1'b0, 1'b0, 1'b1);
      begin repeat (60) @(negedge clk); wr(8'h98, 8'h40); end
    join
    rd(8'h98, r); check("R8 abandoned ri", r, 8'h40);
    rd(8'h99, r); check("R8 abandoned buffer", r, 8'hE7);

    // stop-bit error overlay R3
    fe_select = 1'b1;
    wr(8'h98, 8'h50);
    rd(8'h98, r); check("R3 fe cleared", {7'd0, r[7]}, 8'h00);
    send(8'h0A, 1'b0, 1'b0, 1'b0);
    rd(8'h98, r); check("R3 fe set", r, 8'hD1);
    repeat (40) @(negedge clk);
    rd(8'h98, r); check("R3 fe sticky", {7'd0, r[7]}, 8'h01);
    wr(8'h98, 8'h50);
    rd(8'h98, r); check("R3 fe sw clear", r, 8'h50);
    fe_select = 1'b0;
    wr(8'h98, 8'h90);
    fe_select = 1'b1;
    wr(8'h98, 8'h10);
    fe_select = 1'b0;
    rd(8'h98, r); check("R3 sm0 untouched", r, 8'h90);

    // transmit R4 R5 R6 R7
    wr(8'h98, 8'h40);
    tx_frame("R4 8-bit frame", 8'hB4, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    rd(8'h98, r); check("R6 TI sticky", r, 8'h42);
    wr(8'h98, 8'hC8);
    tx_frame("R5 9-bit tb8=1", 8'h3C, 1'b1, 1'b1);
    wr(8'h98, 8'h80);
    tx_frame("R5 9-bit tb8=0", 8'hD2, 1'b1, 1'b0);
    wr(8'h98, 8'h00);
    wr(8'h99, 8'h00);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    check("R7 no tx in mode 00", bad[7:0], 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule